// File: doc/BRIEF.md
# I2C Transmit Byte Queue Streamer

This block sits between a small register-write port and an I2C byte serialiser. Software enables the queue, then writes payload bytes one at a time to a data address; each accepted byte lands in a first-in first-out store of up to 64 entries. Whenever the queue holds data, is enabled and is not halted, the streamer presents the oldest byte to the serialiser with a request strobe and removes it when the serialiser reports the byte done, along with the acknowledge result.

A slave NAK halts the streamer: the rejected byte is consumed, the bytes behind it stay in the store, and no further request is made until software writes the flush bit. Two latched interrupt sources (NAK seen, queue drained) each have an enable bit and a write-one-to-clear path, and a status byte exposes the empty flag and a sticky overflow flag for writes that arrive when the store is full. START, STOP and bit-level timing belong to the serialiser and are outside this block.

Top module: `i2c_tx_streamer`

## Requirements
- R1: While reset is asserted and just after it is released, the level is 0, the empty status bit is 1, the overflow bit, both interrupt status bits and `irq_o` are 0, and `byte_req_o` is low.
- R2: A write to address 0 while the enable bit is set appends `wr_data_i` to the queue one cycle later and raises `level_o` by one; a write to address 0 while disabled leaves the queue unchanged.
- R3: `status_o` bit 4 is 1 exactly when the queue holds no bytes; bit 5 is the overflow flag; every other `status_o` bit reads 0. The queue holds at most 64 bytes.
- R4: `byte_req_o` is high exactly when the queue is enabled, not halted and not empty; `byte_o` is then the oldest stored byte, and a cycle with `byte_req_o` and `byte_done_i` both high removes it, so bytes leave in write order.
- R5: A completed byte with `byte_nak_i` high sets interrupt status bit 0 and halts the streamer: `byte_req_o` stays low and the remaining bytes are kept until a flush.
- R6: A completed byte that leaves the queue empty (with no byte written in the same cycle) sets interrupt status bit 1.
- R7: Address 2 writes the interrupt enables (bit 0 NAK, bit 1 drained); `irq_o` is the OR of the status bits ANDed with their enables. Writing ones to address 3 clears the matching status bits; a new event in the same cycle wins over the clear.
- R8: A data write to a full queue is dropped and sets the overflow bit, which stays set until a flush.
- R9: A write to address 1 (control) loads the enable from bit 6; when bit 7 is also set the queue is emptied, the halt and overflow are cleared, and the empty bit reads 1 in the next cycle. A done strobe in the flush cycle is ignored.
- R10: `byte_done_i` while `byte_req_o` is low removes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0 data, 1 control, 2 interrupt enable, 3 interrupt clear |
| wr_data_i | input | 8 | Register write data |
| byte_req_o | output | 1 | Byte offered to the serialiser |
| byte_o | output | 8 | Byte offered to the serialiser |
| byte_done_i | input | 1 | Serialiser finished the offered byte |
| byte_nak_i | input | 1 | Slave did not acknowledge the finished byte |
| status_o | output | 8 | Bit 4 empty, bit 5 overflow |
| irq_stat_o | output | 2 | Latched interrupt sources: bit 0 NAK, bit 1 drained |
| irq_o | output | 1 | Enabled interrupt request |
| level_o | output | 7 | Number of stored bytes |

## Verification
The bench runs a behavioural queue model against the design every cycle while a responder plays the serialiser with a chosen latency and an optional NAK on a chosen byte. It goes after the NAK halt (a design that keeps streaming or drops the tail would show a falling level or a live request), the store filling to exactly 64 with one write too many (an off-by-one full flag would accept or lose a byte and the overflow bit would disagree), and the flush (a late pointer reset would leave the empty bit low one cycle, and a flush that forgets the halt or overflow would leave them stuck). It also strobes done while no request is pending, which a design without the request gate would turn into a silent byte loss.

// File: rtl/i2c_txq_pkg.sv
`timescale 1ns/1ps
package i2c_txq_pkg;
  localparam int unsigned ADDR_W = 2;
  localparam int unsigned BYTE_W = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_DATA    = 2'd0,
    REG_CTRL    = 2'd1,
    REG_IRQ_EN  = 2'd2,
    REG_IRQ_CLR = 2'd3
  } txq_reg_e;

  localparam int unsigned CTRL_EN_BIT    = 6;
  localparam int unsigned CTRL_FLUSH_BIT = 7;
  localparam int unsigned ST_EMPTY_BIT   = 4;
  localparam int unsigned ST_OVF_BIT     = 5;
  localparam int unsigned IRQ_NAK_BIT    = 0;
  localparam int unsigned IRQ_DRAIN_BIT  = 1;
  localparam int unsigned IRQ_N          = 2;
endpackage

// File: rtl/i2c_txq_fifo.sv
`timescale 1ns/1ps
module i2c_txq_fifo #(
  parameter  int unsigned DEPTH  = 64,
  parameter  int unsigned DATA_W = 8,
  localparam int unsigned PTR_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              flush_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] push_data_i,
  input  logic              pop_i,
  output logic [DATA_W-1:0] head_o,
  output logic              empty_o,
  output logic              full_o,
  output logic              last_o,
  output logic [CNT_W-1:0]  level_o
);
  localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
  localparam logic [PTR_W-1:0] LAST_IDX = PTR_W'(DEPTH - 1);

  logic [DATA_W-1:0] mem_q [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, rd_ptr_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              push_ok, pop_ok;

  function automatic logic [PTR_W-1:0] ptr_inc(input logic [PTR_W-1:0] p);
    return (p == LAST_IDX) ? '0 : p + 1'b1;
  endfunction

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == DEPTH_C);
  assign last_o  = (cnt_q == CNT_W'(1));
  assign level_o = cnt_q;
  assign head_o  = mem_q[rd_ptr_q];
  assign push_ok = push_i && !full_o && !flush_i;
  assign pop_ok  = pop_i && !empty_o && !flush_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else if (flush_i) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= ptr_inc(wr_ptr_q);
      if (pop_ok)  rd_ptr_q <= ptr_inc(rd_ptr_q);
      case ({push_ok, pop_ok})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk_i) begin
    if (push_ok) mem_q[wr_ptr_q] <= push_data_i;
  end

  // R3
  level_max_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    level_o <= DEPTH_C);
  // R9
  flush_empty_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    flush_i |=> empty_o);
  // R8
  full_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    full_o && push_i && !pop_i && !flush_i |=> full_o);
endmodule

// File: rtl/i2c_txq_issue.sv
`timescale 1ns/1ps
module i2c_txq_issue #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              enable_i,
  input  logic              flush_i,
  input  logic              empty_i,
  input  logic              last_i,
  input  logic              push_i,
  input  logic [DATA_W-1:0] head_i,
  input  logic              done_i,
  input  logic              nak_i,
  output logic              byte_req_o,
  output logic [DATA_W-1:0] byte_o,
  output logic              pop_o,
  output logic              nak_evt_o,
  output logic              drain_evt_o
);
  logic halt_q;

  assign byte_req_o  = enable_i && !halt_q && !empty_i;
  assign byte_o      = head_i;
  assign pop_o       = byte_req_o && done_i && !flush_i;
  assign nak_evt_o   = pop_o && nak_i;
  // last byte leaves and nothing arrives behind it
  assign drain_evt_o = pop_o && last_i && !push_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        halt_q <= 1'b0;
    else if (flush_i)   halt_q <= 1'b0;
    else if (nak_evt_o) halt_q <= 1'b1;
  end

  // R5
  nak_halts_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_evt_o |=> !byte_req_o);
  // R5
  halt_until_flush_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_req_o && !empty_i && enable_i && !flush_i && $past(!byte_req_o) |=> !byte_req_o || $past(flush_i));
endmodule

// File: rtl/i2c_txq_regs.sv
`timescale 1ns/1ps
module i2c_txq_regs
  import i2c_txq_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              nak_evt_i,
  input  logic              drain_evt_i,
  input  logic              full_i,
  output logic              enable_o,
  output logic              flush_o,
  output logic              push_o,
  output logic              overflow_o,
  output logic [IRQ_N-1:0]  irq_stat_o,
  output logic              irq_o
);
  logic             sel_data, sel_ctrl, sel_ie, sel_clr;
  logic             en_q, ovf_q, ovf_evt;
  logic [IRQ_N-1:0] ie_q, stat_q, set_v, clr_v;

  assign sel_data = wr_en_i && (wr_addr_i == REG_DATA);
  assign sel_ctrl = wr_en_i && (wr_addr_i == REG_CTRL);
  assign sel_ie   = wr_en_i && (wr_addr_i == REG_IRQ_EN);
  assign sel_clr  = wr_en_i && (wr_addr_i == REG_IRQ_CLR);

  assign flush_o  = sel_ctrl && wr_data_i[CTRL_FLUSH_BIT];
  assign push_o   = sel_data && en_q;
  assign ovf_evt  = push_o && full_i;

  always_comb begin
    set_v                = '0;
    set_v[IRQ_NAK_BIT]   = nak_evt_i;
    set_v[IRQ_DRAIN_BIT] = drain_evt_i;
    clr_v                = sel_clr ? wr_data_i[IRQ_N-1:0] : '0;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q   <= 1'b0;
      ie_q   <= '0;
      stat_q <= '0;
      ovf_q  <= 1'b0;
    end else begin
      if (sel_ctrl) en_q <= wr_data_i[CTRL_EN_BIT];
      if (sel_ie)   ie_q <= wr_data_i[IRQ_N-1:0];
      stat_q <= (stat_q & ~clr_v) | set_v;
      if (flush_o)      ovf_q <= 1'b0;
      else if (ovf_evt) ovf_q <= 1'b1;
    end
  end

  assign enable_o   = en_q;
  assign overflow_o = ovf_q;
  assign irq_stat_o = stat_q;
  assign irq_o      = |(stat_q & ie_q);

  // R8
  ovf_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overflow_o && !flush_o |=> overflow_o);
  // R5
  nak_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nak_evt_i |=> irq_stat_o[IRQ_NAK_BIT]);
  // R6
  drain_flag_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drain_evt_i |=> irq_stat_o[IRQ_DRAIN_BIT]);
endmodule

// File: rtl/i2c_tx_streamer.sv
`timescale 1ns/1ps
module i2c_tx_streamer
  import i2c_txq_pkg::*;
#(
  parameter  int unsigned DEPTH = 64,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output logic              byte_req_o,
  output logic [BYTE_W-1:0] byte_o,
  input  logic              byte_done_i,
  input  logic              byte_nak_i,
  output logic [BYTE_W-1:0] status_o,
  output logic [IRQ_N-1:0]  irq_stat_o,
  output logic              irq_o,
  output logic [CNT_W-1:0]  level_o
);
  logic              enable, flush, push, pop, overflow;
  logic              empty, full, last, nak_evt, drain_evt;
  logic [BYTE_W-1:0] head;

  i2c_txq_regs u_regs (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .nak_evt_i   (nak_evt),
    .drain_evt_i (drain_evt),
    .full_i      (full),
    .enable_o    (enable),
    .flush_o     (flush),
    .push_o      (push),
    .overflow_o  (overflow),
    .irq_stat_o  (irq_stat_o),
    .irq_o       (irq_o)
  );

  i2c_txq_fifo #(.DEPTH(DEPTH), .DATA_W(BYTE_W)) u_fifo (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .flush_i     (flush),
    .push_i      (push),
    .push_data_i (wr_data_i),
    .pop_i       (pop),
    .head_o      (head),
    .empty_o     (empty),
    .full_o      (full),
    .last_o      (last),
    .level_o     (level_o)
  );

  i2c_txq_issue #(.DATA_W(BYTE_W)) u_issue (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .enable_i    (enable),
    .flush_i     (flush),
    .empty_i     (empty),
    .last_i      (last),
    .push_i      (push),
    .head_i      (head),
    .done_i      (byte_done_i),
    .nak_i       (byte_nak_i),
    .byte_req_o  (byte_req_o),
    .byte_o      (byte_o),
    .pop_o       (pop),
    .nak_evt_o   (nak_evt),
    .drain_evt_o (drain_evt)
  );

  always_comb begin
    status_o               = '0;
    status_o[ST_EMPTY_BIT] = empty;
    status_o[ST_OVF_BIT]   = overflow;
  end

  // R10
  no_pop_without_req_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_req_o && !flush |=> level_o >= $past(level_o));
  // R4
  req_needs_data_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_req_o |-> !status_o[ST_EMPTY_BIT]);
endmodule

// File: tb/tb_i2c_tx_streamer.sv
`timescale 1ns/1ps
module tb_i2c_tx_streamer;
  localparam int DEPTH = 64;
  localparam int CNT_W = $clog2(DEPTH + 1);

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #5 clk = ~clk;

  logic             wr_en_i = 1'b0;
  logic [1:0]       wr_addr_i = '0;
  logic [7:0]       wr_data_i = '0;
  logic             byte_done_i = 1'b0;
  logic             byte_nak_i = 1'b0;
  logic             byte_req_o, irq_o;
  logic [7:0]       byte_o, status_o;
  logic [1:0]       irq_stat_o;
  logic [CNT_W-1:0] level_o;

  i2c_tx_streamer #(.DEPTH(DEPTH)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
    .wr_data_i(wr_data_i), .byte_req_o(byte_req_o), .byte_o(byte_o),
    .byte_done_i(byte_done_i), .byte_nak_i(byte_nak_i), .status_o(status_o),
    .irq_stat_o(irq_stat_o), .irq_o(irq_o), .level_o(level_o)
  );

  int checks = 0;
  int failures = 0;

  logic [7:0] mq[$];
  bit m_en = 0, m_halt = 0, m_ovf = 0;
  bit [1:0] m_st = 0, m_ie = 0;

  bit resp_hold = 1;
  int resp_lat = 0, resp_cnt = 0, nak_at = -1, sent_cnt = 0;
  bit force_done = 0;
  bit cmp_on = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s act=0x%0h exp=0x%0h", tag, act, exp);
    end
  endtask

  // serialiser stand-in
  always @(negedge clk) begin
    if (byte_req_o && !resp_hold) begin
      if (resp_cnt >= resp_lat) begin
        byte_done_i <= 1'b1;
        byte_nak_i  <= (sent_cnt == nak_at);
        sent_cnt++;
        resp_cnt = 0;
      end else begin
        byte_done_i <= 1'b0;
        byte_nak_i  <= 1'b0;
        resp_cnt++;
      end
    end else begin
      byte_done_i <= force_done;
      byte_nak_i  <= 1'b0;
    end
  end

  // reference model
  always @(posedge clk) begin
    automatic bit req, flush, pop, push, full, nak_e, drain_e;
    if (!rst_ni) begin
      mq.delete();
      m_en = 0; m_halt = 0; m_ovf = 0; m_st = 0; m_ie = 0;
    end else begin
      req = m_en && !m_halt && (mq.size() != 0);
      flush = wr_en_i && (wr_addr_i == 2'd1) && wr_data_i[7];
      nak_e = 0; drain_e = 0;
      if (flush) begin
        mq.delete();
        m_halt = 0;
        m_ovf = 0;
      end else begin
        pop  = req && byte_done_i;
        push = wr_en_i && (wr_addr_i == 2'd0) && m_en;
        full = (mq.size() >= DEPTH);
        if (push && full) m_ovf = 1;
        if (pop) begin
          void'(mq.pop_front());
          if (byte_nak_i) begin m_halt = 1; nak_e = 1; end
          if (mq.size() == 0 && !push) drain_e = 1;
        end
        if (push && !full) mq.push_back(wr_data_i);
      end
      if (wr_en_i && wr_addr_i == 2'd1) m_en = wr_data_i[6];
      if (wr_en_i && wr_addr_i == 2'd2) m_ie = wr_data_i[1:0];
      if (wr_en_i && wr_addr_i == 2'd3) m_st = m_st & ~wr_data_i[1:0];
      if (nak_e)   m_st[0] = 1;
      if (drain_e) m_st[1] = 1;
    end
  end

  // per-cycle comparison
  always @(posedge clk) begin
    automatic int sz;
    automatic bit ereq;
    #2;
    if (cmp_on) begin
      sz = mq.size();
      ereq = m_en && !m_halt && (sz != 0);
      chk(level_o == CNT_W'(sz), "R2 level", int'(level_o), sz);
      chk(status_o[4] == (sz == 0), "R3 empty bit", int'(status_o[4]), int'(sz == 0));
      chk((status_o & 8'hCF) == 8'h00, "R3 unused status bits", int'(status_o), 0);
      chk(status_o[5] == m_ovf, "R8 overflow bit", int'(status_o[5]), int'(m_ovf));
      chk(byte_req_o == ereq, "R4 byte request", int'(byte_req_o), int'(ereq));
      if (ereq) chk(byte_o == mq[0], "R4 head byte", int'(byte_o), int'(mq[0]));
      chk(irq_stat_o[0] == m_st[0], "R5 nak flag", int'(irq_stat_o[0]), int'(m_st[0]));
      chk(irq_stat_o[1] == m_st[1], "R6 drained flag", int'(irq_stat_o[1]), int'(m_st[1]));
      chk(irq_o == |(m_st & m_ie), "R7 irq", int'(irq_o), int'(|(m_st & m_ie)));
    end
  end

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
  endtask

  task automatic idle();
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic wait_drain();
    for (int n = 0; n < 2000 && mq.size() != 0; n++) @(negedge clk);
    @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    checks++; failures++;
    $display("FAIL watchdog R4 act=0x0 exp=0x1");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 state under reset
    chk(level_o == 0, "R1 level", int'(level_o), 0);
    chk(status_o == 8'h10, "R1 status", int'(status_o), 'h10);
    chk(!byte_req_o && !irq_o && irq_stat_o == 0, "R1 req/irq", int'({byte_req_o, irq_o, irq_stat_o}), 0);
    rst_ni = 1'b1;
    cmp_on = 1;
    @(negedge clk);
    chk(status_o == 8'h10 && level_o == 0, "R1 after release", int'(status_o), 'h10);

    // R2 disabled writes ignored
    wr(2'd0, 8'hA5); idle();
    chk(level_o == 0, "R2 write while disabled", int'(level_o), 0);

    // enable, both irq enables, stream five bytes
    wr(2'd2, 8'h03);
    wr(2'd1, 8'h40);
    for (int i = 0; i < 5; i++) wr(2'd0, 8'(i * 37 + 11));
    idle();
    chk(level_o == 5, "R2 five queued", int'(level_o), 5);
    chk(byte_req_o && byte_o == 8'd11, "R4 first byte offered", int'(byte_o), 11);
    resp_lat = 2; resp_hold = 0;
    wait_drain();
    chk(irq_stat_o[1] && irq_o, "R6 drained irq", int'({irq_stat_o[1], irq_o}), 3);
    wr(2'd3, 8'h02); idle();
    chk(irq_stat_o == 0 && !irq_o, "R7 clear", int'(irq_stat_o), 0);

    // R5 NAK on second byte
    resp_hold = 1; sent_cnt = 0; nak_at = 1; resp_cnt = 0;
    for (int i = 0; i < 4; i++) wr(2'd0, 8'(8'hC0 + i));
    idle();
    resp_hold = 0;
    repeat (20) @(negedge clk);
    chk(level_o == 2, "R5 tail kept", int'(level_o), 2);
    chk(!byte_req_o, "R5 halted", int'(byte_req_o), 0);
    chk(irq_stat_o[0] && irq_o, "R5 nak irq", int'(irq_stat_o), 1);

    // R10 done without request
    force_done = 1; @(negedge clk); force_done = 0;
    repeat (2) @(negedge clk);
    chk(level_o == 2, "R10 stray done", int'(level_o), 2);

    // R9 flush, empty next cycle
    nak_at = -1;
    wr(2'd1, 8'hC0); idle();
    chk(status_o[4] && level_o == 0, "R9 empty after flush", int'(level_o), 0);
    wr(2'd3, 8'h03);
    for (int i = 0; i < 3; i++) wr(2'd0, 8'(8'h50 + i));
    idle();
    wait_drain();
    chk(level_o == 0 && !byte_req_o, "R9 resumes after flush", int'(level_o), 0);

    // R8 overflow at 64
    resp_hold = 1; resp_lat = 0; resp_cnt = 0;
    for (int i = 0; i < DEPTH + 1; i++) wr(2'd0, 8'(i * 3 + 1));
    idle();
    chk(level_o == DEPTH, "R8 level capped", int'(level_o), DEPTH);
    chk(status_o[5] && !status_o[4], "R8 overflow set", int'(status_o), 'h20);
    resp_hold = 0;
    wait_drain();
    chk(status_o[5], "R8 overflow sticky", int'(status_o[5]), 1);

    // R9 flush mid-stream clears overflow; enable taken from same write
    resp_hold = 1;
    for (int i = 0; i < 3; i++) wr(2'd0, 8'(8'h90 + i));
    wr(2'd1, 8'h80);
    wr(2'd0, 8'h77);
    idle();
    chk(level_o == 0 && !status_o[5], "R9 flush clears, disables", int'(level_o), 0);
    wr(2'd1, 8'h40); idle();
    repeat (3) @(negedge clk);

    cmp_on = 0;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule